// File: doc/BRIEF.md
# Two-Level Segment/Page Address Translator

This block turns a virtual address into a real address by walking two tables held in memory. The virtual address is split into a segment index, a page index and a byte offset. The segment index selects an entry in a segment table. That entry locates a page table. The page index then selects a page table entry, which supplies the real page frame. The split depends on three run-time settings:

- the segment span (64 KiB or 1 MiB),
- the page size (2 KiB or 4 KiB),
- the address width (24-bit or 31-bit).

Both tables carry explicit bounds. Each segment table entry also carries a read-only flag and a shared (common) flag.

A requester raises one translation at a time. The walker fetches entries through a single word-wide read port that waits on a ready strobe. It answers with a one-cycle response that carries one of two results:

- a success code, the real address and the shared flag, or
- a fault code (segment, page or protection) with no address.

All settings, the table origin and the table bound are captured when a request is accepted. Changing them during a walk has no effect on that walk.

Top module: `seg_page_xlate`

## Requirements
- R1: After a synchronous reset `busy`, `mem_req` and `resp_valid` are low.
- R2: The real address is the page frame shifted left by the page shift, ORed with the byte offset. The page shift is 12 when `cfg_page_4k`=1 and 11 when it is 0. The segment index is the virtual address shifted right by 20 when `cfg_seg_1m`=1 and by 16 when it is 0. The page index is the bits between the page shift and the segment shift. The frame is page-entry bits [19:0].
- R3: The segment entry is read at `seg_base` + 4 x segment index. The page entry is read at (segment-entry bits [19:0] shifted left by 11) + 4 x page index. While `mem_req` waits without `mem_ready`, `mem_req` stays high and `mem_addr` stays stable.
- R4: A segment index greater than `seg_last` gives fault code 1 (segment) without any memory read.
- R5: A segment entry with bit 31 set gives fault code 1 after exactly one read.
- R6: Fault code 2 (page) is given in two cases. If the page index is greater than segment-entry bits [28:20], the fault comes with no page-entry read. If the page entry has bit 31 set, the fault comes after the page-entry read.
- R7: A write (`req_write`=1) to a segment whose entry has bit 30 set gives fault code 3 (protection) after only the segment-entry read. A read of that segment translates normally.
- R8: On success `resp_common` equals segment-entry bit 29.
- R9: With `cfg_addr31`=0, virtual address bits [30:24] are ignored and real address bits [30:24] are forced to zero. With `cfg_addr31`=1, all 31 bits take part.
- R10: Every faulting response has `resp_raddr`=0 and `resp_common`=0. `resp_valid` is high for exactly one cycle per accepted request.
- R11: A request raised while `busy` is ignored. Configuration changes after acceptance do not alter the walk in progress.
- R12: A successful translation reports fault code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_seg_1m | input | 1 | 1: 1 MiB segments, 0: 64 KiB segments |
| cfg_page_4k | input | 1 | 1: 4 KiB pages, 0: 2 KiB pages |
| cfg_addr31 | input | 1 | 1: 31-bit addressing, 0: 24-bit addressing |
| seg_base | input | 31 | Real byte address of the segment table |
| seg_last | input | 15 | Highest valid segment index |
| req_valid | input | 1 | Translation request, accepted when not busy |
| req_write | input | 1 | Request is a store access |
| req_vaddr | input | 31 | Virtual address to translate |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Table read request, held until ready |
| mem_addr | output | 31 | Byte address of the table entry being read |
| mem_ready | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Table entry word |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 2 | 0 ok, 1 segment, 2 page, 3 protection |
| resp_raddr | output | 31 | Translated real address (0 on fault) |
| resp_common | output | 1 | Shared-segment flag of the translated segment |

## Verification
All four combinations of segment span and page size are tried with addresses whose segment and page fields differ. A wrong field split therefore shows up as a wrong entry address or a wrong real address. Fault cases are placed on both sides of each boundary: the last valid segment against the first one past the bound, and a page index within the page table against one past it. The read count tells apart faults raised before a fetch from faults raised after one. The same addresses are replayed with 24-bit and 31-bit widths, which separates the masking of the virtual input from the masking of the real output. A second request and a configuration change are then pushed during a slow walk, which shows whether anything is sampled after acceptance.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    XF_NONE = 2'd0,
    XF_SEG  = 2'd1,
    XF_PAGE = 2'd2,
    XF_PROT = 2'd3
  } xfault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEG,
    ST_PAGE,
    ST_DONE
  } wstate_e;

  // Entry word layout
  localparam int ENT_INV_BIT  = 31;
  localparam int STE_RO_BIT   = 30;
  localparam int STE_COM_BIT  = 29;
  localparam int STE_LAST_LSB = 20;

  // Address field geometry
  localparam int SEG_SH_S  = 16;
  localparam int SEG_SH_L  = 20;
  localparam int PG_SH_S   = 11;
  localparam int PG_SH_L   = 12;
  localparam int NARROW_AW = 24;
  localparam int ORG_SHIFT = 11;

endpackage

// File: rtl/xlate_split.sv
module xlate_split
  import xlate_pkg::*;
#(
  parameter int AW  = 31,
  parameter int SIW = 15,
  parameter int PIW = 9,
  parameter int OFW = 12
) (
  input  logic [AW-1:0]  va,
  input  logic           seg_1m,
  input  logic           page_4k,
  input  logic           addr31,
  output logic [SIW-1:0] seg_idx,
  output logic [PIW-1:0] pg_idx,
  output logic [OFW-1:0] off
);

  localparam logic [AW-1:0] ONE         = AW'(1);
  localparam logic [AW-1:0] NARROW_MASK = (ONE << NARROW_AW) - ONE;

  logic [AW-1:0] va_m;
  logic [AW-1:0] pg_mask;
  logic [AW-1:0] off_mask;
  logic [4:0]    sh_seg;
  logic [4:0]    sh_pg;

  always_comb begin
    va_m     = addr31 ? va : (va & NARROW_MASK);
    sh_seg   = seg_1m  ? 5'(SEG_SH_L) : 5'(SEG_SH_S);
    sh_pg    = page_4k ? 5'(PG_SH_L)  : 5'(PG_SH_S);
    pg_mask  = (ONE << (sh_seg - sh_pg)) - ONE;
    off_mask = (ONE << sh_pg) - ONE;
    seg_idx  = SIW'(va_m >> sh_seg);
    pg_idx   = PIW'((va_m >> sh_pg) & pg_mask);
    off      = OFW'(va_m & off_mask);
  end

endmodule

// File: rtl/xlate_entry_decode.sv
module xlate_entry_decode
  import xlate_pkg::*;
#(
  parameter int AW      = 31,
  parameter int DW      = 32,
  parameter int PIW     = 9,
  parameter int ORG_W   = 20,
  parameter int FRAME_W = 20
) (
  input  logic [DW-1:0]      word,
  output logic               ent_inv,
  output logic               ste_ro,
  output logic               ste_common,
  output logic [PIW-1:0]     ste_pt_last,
  output logic [AW-1:0]      ste_pt_org,
  output logic [FRAME_W-1:0] pte_frame
);

  assign ent_inv     = word[ENT_INV_BIT];
  assign ste_ro      = word[STE_RO_BIT];
  assign ste_common  = word[STE_COM_BIT];
  assign ste_pt_last = word[STE_LAST_LSB +: PIW];
  assign ste_pt_org  = AW'({word[ORG_W-1:0], {ORG_SHIFT{1'b0}}});
  assign pte_frame   = word[FRAME_W-1:0];

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
#(
  parameter int AW      = 31,
  parameter int SIW     = 15,
  parameter int PIW     = 9,
  parameter int OFW     = 12,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [SIW-1:0]     seg_idx,
  input  logic [PIW-1:0]     pg_idx,
  input  logic [OFW-1:0]     off,
  input  logic               page_4k,
  input  logic               addr31,
  input  logic [AW-1:0]      seg_base,
  input  logic [SIW-1:0]     seg_last,
  input  logic               mem_ready,
  input  logic               ent_inv,
  input  logic               ste_ro,
  input  logic               ste_common,
  input  logic [PIW-1:0]     ste_pt_last,
  input  logic [AW-1:0]      ste_pt_org,
  input  logic [FRAME_W-1:0] pte_frame,
  output logic               busy,
  output logic               mem_req,
  output logic [AW-1:0]      mem_addr,
  output logic               resp_valid,
  output logic [1:0]         resp_fault,
  output logic [AW-1:0]      resp_raddr,
  output logic               resp_common
);

  localparam int            RW          = FRAME_W + PG_SH_L;
  localparam logic [AW-1:0] ONE         = AW'(1);
  localparam logic [AW-1:0] NARROW_MASK = (ONE << NARROW_AW) - ONE;

  wstate_e        state;
  logic           r_write;
  logic           r_p4k;
  logic           r_a31;
  logic           r_common;
  logic [PIW-1:0] r_pg;
  logic [OFW-1:0] r_off;

  logic [RW-1:0]  frame_wide;
  logic [AW-1:0]  raddr_full;
  logic [AW-1:0]  raddr_final;

  always_comb begin
    frame_wide  = RW'(pte_frame) << (r_p4k ? PG_SH_L : PG_SH_S);
    raddr_full  = AW'(frame_wide) | AW'(r_off);
    raddr_final = r_a31 ? raddr_full : (raddr_full & NARROW_MASK);
  end

  assign busy       = (state != ST_IDLE);
  assign resp_valid = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      resp_fault  <= XF_NONE;
      resp_raddr  <= '0;
      resp_common <= 1'b0;
      r_write     <= 1'b0;
      r_p4k       <= 1'b0;
      r_a31       <= 1'b0;
      r_common    <= 1'b0;
      r_pg        <= '0;
      r_off       <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            r_write     <= req_write;
            r_p4k       <= page_4k;
            r_a31       <= addr31;
            r_pg        <= pg_idx;
            r_off       <= off;
            resp_fault  <= XF_NONE;
            resp_raddr  <= '0;
            resp_common <= 1'b0;
            if (seg_idx > seg_last) begin
              resp_fault <= XF_SEG;
              state      <= ST_DONE;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= seg_base + {{(AW-SIW-2){1'b0}}, seg_idx, 2'b00};
              state    <= ST_SEG;
            end
          end
        end
        ST_SEG: begin
          if (mem_ready) begin
            if (ent_inv) begin
              resp_fault <= XF_SEG;
              mem_req    <= 1'b0;
              state      <= ST_DONE;
            end else if (r_write && ste_ro) begin
              resp_fault <= XF_PROT;
              mem_req    <= 1'b0;
              state      <= ST_DONE;
            end else if (r_pg > ste_pt_last) begin
              resp_fault <= XF_PAGE;
              mem_req    <= 1'b0;
              state      <= ST_DONE;
            end else begin
              r_common <= ste_common;
              mem_addr <= ste_pt_org + {{(AW-PIW-2){1'b0}}, r_pg, 2'b00};
              state    <= ST_PAGE;
            end
          end
        end
        ST_PAGE: begin
          if (mem_ready) begin
            mem_req <= 1'b0;
            state   <= ST_DONE;
            if (ent_inv) begin
              resp_fault <= XF_PAGE;
            end else begin
              resp_raddr  <= raddr_final;
              resp_common <= r_common;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import xlate_pkg::*;
#(
  parameter int AW      = 31,
  parameter int DW      = 32,
  parameter int SIW     = 15,
  parameter int PIW     = 9,
  parameter int OFW     = 12,
  parameter int ORG_W   = 20,
  parameter int FRAME_W = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_seg_1m,
  input  logic           cfg_page_4k,
  input  logic           cfg_addr31,
  input  logic [AW-1:0]  seg_base,
  input  logic [SIW-1:0] seg_last,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_vaddr,
  output logic           busy,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_ready,
  input  logic [DW-1:0]  mem_rdata,
  output logic           resp_valid,
  output logic [1:0]     resp_fault,
  output logic [AW-1:0]  resp_raddr,
  output logic           resp_common
);

  logic [SIW-1:0]     seg_idx;
  logic [PIW-1:0]     pg_idx;
  logic [OFW-1:0]     off;
  logic               ent_inv;
  logic               ste_ro;
  logic               ste_common;
  logic [PIW-1:0]     ste_pt_last;
  logic [AW-1:0]      ste_pt_org;
  logic [FRAME_W-1:0] pte_frame;

  xlate_split #(.AW(AW), .SIW(SIW), .PIW(PIW), .OFW(OFW)) u_split (
    .va      (req_vaddr),
    .seg_1m  (cfg_seg_1m),
    .page_4k (cfg_page_4k),
    .addr31  (cfg_addr31),
    .seg_idx (seg_idx),
    .pg_idx  (pg_idx),
    .off     (off)
  );

  xlate_entry_decode #(
    .AW(AW), .DW(DW), .PIW(PIW), .ORG_W(ORG_W), .FRAME_W(FRAME_W)
  ) u_decode (
    .word        (mem_rdata),
    .ent_inv     (ent_inv),
    .ste_ro      (ste_ro),
    .ste_common  (ste_common),
    .ste_pt_last (ste_pt_last),
    .ste_pt_org  (ste_pt_org),
    .pte_frame   (pte_frame)
  );

  xlate_walker #(
    .AW(AW), .SIW(SIW), .PIW(PIW), .OFW(OFW), .FRAME_W(FRAME_W)
  ) u_walker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .seg_idx     (seg_idx),
    .pg_idx      (pg_idx),
    .off         (off),
    .page_4k     (cfg_page_4k),
    .addr31      (cfg_addr31),
    .seg_base    (seg_base),
    .seg_last    (seg_last),
    .mem_ready   (mem_ready),
    .ent_inv     (ent_inv),
    .ste_ro      (ste_ro),
    .ste_common  (ste_common),
    .ste_pt_last (ste_pt_last),
    .ste_pt_org  (ste_pt_org),
    .pte_frame   (pte_frame),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .resp_valid  (resp_valid),
    .resp_fault  (resp_fault),
    .resp_raddr  (resp_raddr),
    .resp_common (resp_common)
  );

endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int AW = 31
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic          resp_valid,
  input logic [1:0]    resp_fault,
  input logic [AW-1:0] resp_raddr,
  input logic          resp_common
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!busy && !mem_req && !resp_valid));

  assert_hold_read_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  assert_read_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_fault_no_addr_R10: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault != 2'd0) |-> (resp_raddr == '0 && !resp_common));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  assert_resp_after_reads_R10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !mem_req);

endmodule

bind seg_page_xlate xlate_checker u_chk (.*);

// File: tb/seg_page_xlate_bench.sv
module seg_page_xlate_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_seg_1m = 1'b0;
  logic        cfg_page_4k = 1'b1;
  logic        cfg_addr31 = 1'b1;
  logic [30:0] seg_base = 31'd0;
  logic [14:0] seg_last = 15'd3;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [30:0] req_vaddr = 31'd0;
  logic        busy;
  logic        mem_req;
  logic [30:0] mem_addr;
  logic        mem_ready;
  logic [31:0] mem_rdata;
  logic        resp_valid;
  logic [1:0]  resp_fault;
  logic [30:0] resp_raddr;
  logic        resp_common;

  seg_page_xlate u_seg_page_xlate (
    .clk(clk), .rst(rst),
    .cfg_seg_1m(cfg_seg_1m), .cfg_page_4k(cfg_page_4k), .cfg_addr31(cfg_addr31),
    .seg_base(seg_base), .seg_last(seg_last),
    .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .resp_valid(resp_valid), .resp_fault(resp_fault),
    .resp_raddr(resp_raddr), .resp_common(resp_common)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model: 16 KiB of words, fixed extra latency per read
  logic [31:0] mem [0:4095];
  int          mem_lat = 0;
  int          wait_cnt = 0;
  int          rd_total = 0;
  logic [30:0] rd_log [0:255];
  int          resp_cnt = 0;

  function automatic logic [31:0] rd_word(input logic [30:0] a);
    if (a < 31'd16384) return mem[a[13:2]];
    return 32'h8000_0000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mem_ready <= 1'b0;
      mem_rdata <= 32'd0;
      wait_cnt  <= 0;
    end else begin
      mem_ready <= 1'b0;
      if (mem_req && !mem_ready) begin
        if (wait_cnt >= mem_lat) begin
          mem_ready <= 1'b1;
          mem_rdata <= rd_word(mem_addr);
          rd_log[rd_total[7:0]] <= mem_addr;
          rd_total <= rd_total + 1;
          wait_cnt <= 0;
        end else begin
          wait_cnt <= wait_cnt + 1;
        end
      end
    end
  end

  always @(posedge clk) if (!rst && resp_valid) resp_cnt <= resp_cnt + 1;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ste(input logic inv, input logic ro, input logic com,
                                         input logic [8:0] last, input logic [19:0] org);
    return {inv, ro, com, last, org};
  endfunction

  logic [1:0]  o_fault;
  logic [30:0] o_ra;
  logic        o_com;
  int          o_nrd;
  logic [30:0] o_a0;
  logic [30:0] o_a1;

  task automatic set_cfg(input logic s1m, input logic p4k, input logic a31);
    @(negedge clk);
    cfg_seg_1m  = s1m;
    cfg_page_4k = p4k;
    cfg_addr31  = a31;
  endtask

  task automatic run_xlate(input logic [30:0] va, input logic wr);
    int start;
    int t;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_vaddr = va;
    start = rd_total;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!resp_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk("R10", "response arrives", 32'(resp_valid), 32'd1);
    o_fault = resp_fault;
    o_ra    = resp_raddr;
    o_com   = resp_common;
    o_nrd   = rd_total - start;
    o_a0    = rd_log[start[7:0]];
    o_a1    = rd_log[8'(start + 1)];
    @(negedge clk);
    chk("R10", "response lasts one cycle", 32'(resp_valid), 32'd0);
  endtask

  task automatic expect_ok(input string tag, input logic [30:0] va, input logic wr,
                           input logic [30:0] ra, input logic com,
                           input logic [30:0] a0, input logic [30:0] a1);
    run_xlate(va, wr);
    chk("R12", "success code", 32'(o_fault), 32'd0);
    chk(tag, "real address", 32'(o_ra), 32'(ra));
    chk("R8", "common flag", 32'(o_com), 32'(com));
    chk("R3", "read count", 32'(o_nrd), 32'd2);
    chk("R3", "segment entry address", 32'(o_a0), 32'(a0));
    chk("R3", "page entry address", 32'(o_a1), 32'(a1));
  endtask

  task automatic expect_fault(input string tag, input logic [30:0] va, input logic wr,
                              input logic [1:0] code, input int nrd);
    run_xlate(va, wr);
    chk(tag, "fault code", 32'(o_fault), 32'(code));
    chk("R10", "faulting address is zero", 32'(o_ra), 32'd0);
    chk("R10", "faulting common is zero", 32'(o_com), 32'd0);
    chk(tag, "read count", 32'(o_nrd), 32'(nrd));
  endtask

  task automatic t_reset;
    chk("R1", "busy after reset", 32'(busy), 32'd0);
    chk("R1", "mem_req after reset", 32'(mem_req), 32'd0);
    chk("R1", "resp_valid after reset", 32'(resp_valid), 32'd0);
  endtask

  task automatic t_sizes;
    set_cfg(1'b0, 1'b1, 1'b1);
    expect_ok("R2", 31'h0000_3ABC, 1'b0, 31'h0010_3ABC, 1'b0, 31'h0, 31'h80C);
    expect_ok("R2", 31'h0003_1020, 1'b0, 31'h0030_1020, 1'b0, 31'hC, 31'h1004);
    set_cfg(1'b0, 1'b0, 1'b1);
    expect_ok("R2", 31'h0000_3923, 1'b0, 31'h0008_3923, 1'b0, 31'h0, 31'h81C);
    set_cfg(1'b1, 1'b1, 1'b1);
    expect_ok("R2", 31'h000C_8055, 1'b0, 31'h001C_8055, 1'b0, 31'h0, 31'hB20);
    expect_ok("R2", 31'h0030_1020, 1'b0, 31'h0030_1020, 1'b0, 31'hC, 31'h1004);
    set_cfg(1'b1, 1'b0, 1'b1);
    expect_ok("R2", 31'h000F_FFFF, 1'b0, 31'h0017_FFFF, 1'b0, 31'h0, 31'hFFC);
  endtask

  task automatic t_seg_bound;
    set_cfg(1'b0, 1'b1, 1'b1);
    expect_fault("R4", 31'h0004_0000, 1'b0, 2'd1, 0);
    set_cfg(1'b1, 1'b1, 1'b1);
    expect_fault("R4", 31'h0040_0000, 1'b0, 2'd1, 0);
  endtask

  task automatic t_seg_invalid;
    set_cfg(1'b0, 1'b1, 1'b1);
    expect_fault("R5", 31'h0001_0010, 1'b0, 2'd1, 1);
    chk("R5", "segment entry address", 32'(o_a0), 32'h4);
  endtask

  task automatic t_page_fault;
    set_cfg(1'b0, 1'b1, 1'b1);
    expect_fault("R6", 31'h0003_2000, 1'b0, 2'd2, 1);
    expect_fault("R6", 31'h0000_5000, 1'b0, 2'd2, 2);
  endtask

  task automatic t_protect;
    set_cfg(1'b0, 1'b1, 1'b1);
    expect_ok("R7", 31'h0002_1010, 1'b0, 31'h0010_1010, 1'b1, 31'h8, 31'h804);
    expect_fault("R7", 31'h0002_1010, 1'b1, 2'd3, 1);
    expect_fault("R7", 31'h0002_9000, 1'b1, 2'd3, 1);
    expect_ok("R7", 31'h0000_3ABC, 1'b1, 31'h0010_3ABC, 1'b0, 31'h0, 31'h80C);
  endtask

  task automatic t_narrow;
    set_cfg(1'b0, 1'b1, 1'b1);
    expect_ok("R9", 31'h0000_6678, 1'b0, 31'h1234_5678, 1'b0, 31'h0, 31'h818);
    expect_fault("R9", 31'h4000_0000, 1'b0, 2'd1, 0);
    set_cfg(1'b0, 1'b1, 1'b0);
    expect_ok("R9", 31'h0000_6678, 1'b0, 31'h0034_5678, 1'b0, 31'h0, 31'h818);
    expect_ok("R9", 31'h7F00_3ABC, 1'b0, 31'h0010_3ABC, 1'b0, 31'h0, 31'h80C);
    expect_ok("R9", 31'h4000_0000, 1'b0, 31'h0010_0000, 1'b0, 31'h0, 31'h800);
  endtask

  task automatic t_busy;
    int start;
    int pulses;
    int t;
    set_cfg(1'b0, 1'b1, 1'b1);
    mem_lat = 3;
    @(negedge clk);
    start  = rd_total;
    pulses = resp_cnt;
    req_valid = 1'b1;
    req_write = 1'b0;
    req_vaddr = 31'h0000_3ABC;
    @(negedge clk);
    chk("R11", "busy after acceptance", 32'(busy), 32'd1);
    req_write   = 1'b1;
    req_vaddr   = 31'h0004_0000;
    cfg_seg_1m  = 1'b1;
    cfg_page_4k = 1'b0;
    cfg_addr31  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!resp_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk("R11", "first request answered", 32'(resp_fault), 32'd0);
    chk("R11", "address uses captured setup", 32'(resp_raddr), 32'h0010_3ABC);
    chk("R3", "slow memory read count", 32'(rd_total - start), 32'd2);
    chk("R3", "slow segment entry address", 32'(rd_log[start[7:0]]), 32'h0);
    chk("R3", "slow page entry address", 32'(rd_log[8'(start + 1)]), 32'h80C);
    cfg_seg_1m  = 1'b0;
    cfg_page_4k = 1'b1;
    cfg_addr31  = 1'b1;
    repeat (20) @(negedge clk);
    chk("R11", "only one response", 32'(resp_cnt - pulses), 32'd1);
    mem_lat = 0;
  endtask

  task automatic print_summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
    mem[0] = mk_ste(1'b0, 1'b0, 1'b0, 9'd511, 20'd1);
    mem[1] = mk_ste(1'b1, 1'b0, 1'b0, 9'd511, 20'd1);
    mem[2] = mk_ste(1'b0, 1'b1, 1'b1, 9'd3,   20'd1);
    mem[3] = mk_ste(1'b0, 1'b0, 1'b0, 9'd1,   20'd2);
    for (int i = 0; i < 512; i++) begin
      if (i == 5)      mem[512 + i] = 32'h8000_0000;
      else if (i == 6) mem[512 + i] = 32'h0001_2345;
      else             mem[512 + i] = 32'h0000_0100 + 32'(i);
    end
    mem[1024] = 32'h0000_0300;
    mem[1025] = 32'h0000_0301;
    mem[1026] = 32'h0000_03FF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_seg_bound();
    t_seg_invalid();
    t_page_fault();
    t_protect();
    t_narrow();
    t_busy();
    repeat (2) @(negedge clk);
    print_summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    print_summary();
    $finish;
  end

endmodule